// File: doc/BRIEF.md
# Serial-Gated Carrier Burst Modulator

This block makes a modulated carrier for an infrared-style transmitter. A carrier timer counts either system clock cycles or rising edges of an external clock. Each time it reaches its compare value it reloads and toggles a flip-flop, which gives a square-wave carrier. An 8-bit shift register holds the data pattern. Its serial bit stays inside the block and turns the carrier pin on and off, one bit at a time.

A second timer sets the bit rate. It is a 4-bit prescaler followed by an 8-bit compare counter. Its compare-match toggle clocks the shift register. Burst lengths therefore come in bit periods that do not depend on the carrier frequency. Software writes the compare values and loads a data byte. The block sends the eight bits MSB first and then raises a done flag.

Top module: `burst_mod_top`

## Requirements
- R1: After reset, `burst_o` and `done_o` are 0.
- R2: With `clk_sel_i`=0 and `en_i`=1, the carrier toggles every `car_cmp_i`+1 clock cycles. The carrier counter restarts from 0 on the cycle after it reaches or passes the compare value.
- R3: `burst_o` is the logical AND of the carrier flip-flop and the current serial data bit. It goes low in the same cycle that the data bit goes low.
- R4: A load restarts the bit timer. Bits are sent MSB first. Each bit lasts 2·(`pre_val_i`+1)·(`bit_cmp_i`+1) clock cycles, counted from the clock edge that samples `load_i`. The carrier is not reset by a load, so a burst starts with the carrier's current phase.
- R5: `done_o` goes to 1 at the clock edge that ends the eighth bit. After that, `burst_o` stays 0 and `done_o` stays 1 until the next load.
- R6: `load_i` captures `data_i`, clears `done_o` in the next cycle and starts a new 8-bit sequence.
- R7: With `clk_sel_i`=1, the carrier counter advances once per rising edge of `ext_clk_i`. The edge goes through a two-flop synchronizer, so it takes effect a few cycles late. While `ext_clk_i` is static, the carrier is frozen.
- R8: While `en_i`=0, both timers hold their state. The carrier does not toggle and no bit advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock for the carrier timer |
| clk_sel_i | input | 1 | Carrier clock select: 0 = system clock, 1 = external clock edges |
| en_i | input | 1 | Timer run enable |
| car_cmp_i | input | CAR_W | Carrier compare value (half-period minus 1) |
| pre_val_i | input | PRE_W | Bit-rate prescaler value (divide by value+1) |
| bit_cmp_i | input | BIT_W | Bit-rate compare value |
| load_i | input | 1 | Load strobe for the data pattern |
| data_i | input | SR_W | Data pattern, sent MSB first |
| burst_o | output | 1 | Gated carrier output |
| done_o | output | 1 | All bits sent |

## Verification
The bench uses the default widths: an 8-bit carrier compare, a 4-bit prescaler, an 8-bit bit counter and an 8-bit pattern. It picks small compare values so that each bit period is a whole multiple of the carrier period. The number of high cycles in a bit window is then exactly half the window for a 1 bit, and zero for a 0 bit, whatever the carrier phase. With these values, many patterns finish in a few hundred cycles. The largest prescaler and compare values give a bit period of 8192 cycles. Under that long, steady gate the bench drives the external clock by hand, so it can count the carrier toggles edge by edge.

// File: rtl/burst_mod_pkg.sv
package burst_mod_pkg;
  localparam int unsigned CAR_W_D = 8;
  localparam int unsigned PRE_W_D = 4;
  localparam int unsigned BIT_W_D = 8;
  localparam int unsigned SR_W_D  = 8;
  localparam int unsigned SYNC_N  = 2;
endpackage

// File: rtl/carrier_gen.sv
module carrier_gen import burst_mod_pkg::*; #(
  parameter int unsigned CAR_W = CAR_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clk_sel_i,
  input  logic             ext_clk_i,
  input  logic [CAR_W-1:0] cmp_i,
  output logic             tog_o
);
  localparam int unsigned SW = SYNC_N + 1;

  logic [SW-1:0]    ext_q;
  logic [CAR_W-1:0] cnt_q;
  logic             tog_q;
  logic             ext_rise, tick;

  assign ext_rise = ext_q[SW-2] & ~ext_q[SW-1];
  assign tick     = en_i & (clk_sel_i ? ext_rise : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      ext_q <= {ext_q[SW-2:0], ext_clk_i};
      if (tick) begin
        if (cnt_q >= cmp_i) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/bit_timer.sv
module bit_timer import burst_mod_pkg::*; #(
  parameter int unsigned PRE_W = PRE_W_D,
  parameter int unsigned BIT_W = BIT_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_val_i,
  input  logic [BIT_W-1:0] cmp_i,
  output logic             shift_o
);
  logic [PRE_W-1:0] pre_q;
  logic [BIT_W-1:0] cnt_q;
  logic             tog_q;
  logic             pre_hit, cnt_hit;

  assign pre_hit = pre_q >= pre_val_i;
  assign cnt_hit = cnt_q >= cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (restart_i) begin
      // start high so the first rising toggle lands one full bit later
      pre_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b1;
    end else if (en_i) begin
      if (pre_hit) begin
        pre_q <= '0;
        if (cnt_hit) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign shift_o = en_i & ~restart_i & pre_hit & cnt_hit & ~tog_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift import burst_mod_pkg::*; #(
  parameter int unsigned SR_W = SR_W_D
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            shift_i,
  output logic            ser_o,
  output logic            done_o
);
  localparam int unsigned LW = $clog2(SR_W + 1);

  logic [SR_W-1:0] sr_q;
  logic [LW-1:0]   left_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= data_i;
      left_q <= LW'(SR_W);
      done_q <= 1'b0;
    end else if (shift_i && left_q != '0) begin
      sr_q   <= {sr_q[SR_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
      if (left_q == LW'(1)) done_q <= 1'b1;
    end
  end

  assign ser_o  = (left_q != '0) & sr_q[SR_W-1];
  assign done_o = done_q;
endmodule

// File: rtl/burst_mod_top.sv
module burst_mod_top import burst_mod_pkg::*; #(
  parameter int unsigned CAR_W = CAR_W_D,
  parameter int unsigned PRE_W = PRE_W_D,
  parameter int unsigned BIT_W = BIT_W_D,
  parameter int unsigned SR_W  = SR_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             clk_sel_i,
  input  logic             en_i,
  input  logic [CAR_W-1:0] car_cmp_i,
  input  logic [PRE_W-1:0] pre_val_i,
  input  logic [BIT_W-1:0] bit_cmp_i,
  input  logic             load_i,
  input  logic [SR_W-1:0]  data_i,
  output logic             burst_o,
  output logic             done_o
);
  logic car_tog_w, shift_w, gate_w;

  carrier_gen #(.CAR_W(CAR_W)) u_car (
    .clk_i, .rst_ni, .en_i, .clk_sel_i, .ext_clk_i,
    .cmp_i(car_cmp_i), .tog_o(car_tog_w)
  );

  bit_timer #(.PRE_W(PRE_W), .BIT_W(BIT_W)) u_bit (
    .clk_i, .rst_ni, .en_i, .restart_i(load_i),
    .pre_val_i, .cmp_i(bit_cmp_i), .shift_o(shift_w)
  );

  ser_shift #(.SR_W(SR_W)) u_sr (
    .clk_i, .rst_ni, .load_i, .data_i, .shift_i(shift_w),
    .ser_o(gate_w), .done_o
  );

  // combinational gate: output drops in the cycle the bit goes low
  assign burst_o = gate_w & car_tog_w;
endmodule

// File: rtl/burst_mod_chk.sv
module burst_mod_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic load_i,
  input logic burst_o,
  input logic done_o,
  input logic car_tog_i,
  input logic gate_i
);
  AST_BURST_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> gate_i); // R3
  AST_BURST_NEEDS_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> car_tog_i); // R3
  AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !gate_i); // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R5
  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o); // R6
  AST_HOLD_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(car_tog_i)); // R8
endmodule

bind burst_mod_top burst_mod_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
  .burst_o(burst_o), .done_o(done_o), .car_tog_i(car_tog_w), .gate_i(gate_w)
);

// File: tb/sim_burst_mod_top.sv
module sim_burst_mod_top;
  localparam time CLK_P = 10ns;
  localparam int  NVEC  = 4;
  // {car_cmp, pre_val, bit_cmp, data}; bit period is a multiple of carrier period
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd1, 8'd0, 8'd3, 8'hA5},
    {8'd2, 8'd2, 8'd2, 8'h3C},
    {8'd0, 8'd1, 8'd0, 8'h81},
    {8'd3, 8'd3, 8'd3, 8'h6E}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, clk_sel = 1'b0, en = 1'b1, load = 1'b0;
  logic [7:0] car_cmp = '0, bit_cmp = '0, data = '0;
  logic [3:0] pre_val = '0;
  logic burst, done;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_mod_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .clk_sel_i(clk_sel),
    .en_i(en), .car_cmp_i(car_cmp), .pre_val_i(pre_val), .bit_cmp_i(bit_cmp),
    .load_i(load), .data_i(data), .burst_o(burst), .done_o(done)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] d);
    data = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic count_toggles(input int n, output int tg);
    logic prev;
    tg = 0; prev = burst;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (burst != prev) tg++;
      prev = burst;
    end
  endtask

  initial begin
    int tb, hi, tg, dlast;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 burst after reset", burst, 0);
    check("R1 done after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: table walk
    for (int vi = 0; vi < NVEC; vi++) begin
      v = VEC[vi];
      car_cmp = v[31:24]; pre_val = v[19:16]; bit_cmp = v[15:8];
      tb = 2 * (int'(v[19:16]) + 1) * (int'(v[15:8]) + 1);
      do_load(v[7:0]);
      for (int k = 7; k >= 0; k--) begin
        hi = 0;
        for (int s = 0; s < tb; s++) begin
          hi += int'(burst);
          dlast = int'(done);
          @(negedge clk);
        end
        check($sformatf("R4 vec%0d bit%0d high cycles", vi, k), hi,
              v[k] ? tb / 2 : 0);
      end
      check($sformatf("R5 vec%0d done before end", vi), dlast, 0);
      check($sformatf("R5 vec%0d done at end", vi), done, 1);
      hi = 0;
      for (int s = 0; s < 3 * tb; s++) begin
        hi += int'(burst);
        @(negedge clk);
      end
      check($sformatf("R5 vec%0d silent after done", vi), hi, 0);
      check($sformatf("R5 vec%0d done held", vi), done, 1);
    end

    // R6: reload clears done on the next cycle
    car_cmp = 8'd0; pre_val = 4'd0; bit_cmp = 8'd0;
    do_load(8'hFF);
    check("R6 done cleared by load", done, 0);

    // R2: constant-gate carrier toggles every cmp+1 cycles
    car_cmp = 8'd2; pre_val = 4'd15; bit_cmp = 8'd255;
    do_load(8'hFF);
    count_toggles(60, tg);
    check("R2 carrier toggles in 60 cycles", tg, 20);

    // R3: zero bit holds output low immediately
    do_load(8'h00);
    hi = 0;
    for (int s = 0; s < 40; s++) begin
      hi += int'(burst);
      @(negedge clk);
    end
    check("R3 zero bit gates carrier off", hi, 0);

    // R8: disabled timers freeze carrier and bits
    car_cmp = 8'd0; pre_val = 4'd0; bit_cmp = 8'd0;
    en = 1'b0;
    do_load(8'hFF);
    count_toggles(50, tg);
    check("R8 carrier frozen", tg, 0);
    check("R8 no bits advanced", done, 0);
    en = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 resumes and finishes", done, 1);

    // R7: external clock source
    clk_sel = 1'b1; car_cmp = 8'd0; pre_val = 4'd15; bit_cmp = 8'd255;
    repeat (6) @(negedge clk);
    do_load(8'hFF);
    count_toggles(30, tg);
    check("R7 static ext clock freezes carrier", tg, 0);
    tg = 0;
    for (int p = 0; p < 4; p++) begin
      int t;
      ext_clk = 1'b1;
      count_toggles(4, t); tg += t;
      ext_clk = 1'b0;
      count_toggles(4, t); tg += t;
    end
    begin
      int t;
      count_toggles(6, t); tg += t;
    end
    check("R7 one toggle per ext edge", tg, 4);

    // R1: reset mid-burst
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 burst in reset", burst, 0);
    check("R1 done in reset", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule